// File: doc/BRIEF.md
# Remote DMA Data Port Controller

This block lets a host move bytes between its register bus and a local packet buffer RAM through one data port. The host loads a 16-bit byte count and a start address, each as a low and a high byte register. It then writes a command that selects a read or write transfer and sets the run bit. After that it streams data through the data port register. Each access moves one byte, or a 16-bit word when the word-width bit in the configuration register is set. The count is always kept in bytes.

When the count runs out, a completion flag in the status register sets and the command field falls back to the abort/complete code. The host clears status flags by writing ones to them. During a read transfer, the current address wraps from the ring stop page back to the ring start page, so a buffer that crosses the end of the receive ring is read out in order. Pages are 256 bytes. After reset the command register holds a fixed stopped pattern and the status register shows a reset flag, so a probe can identify the block.

Top module: `rdma_port`

## Requirements
- R1: After reset, the command register (offset 0) reads 0x21, the status register (offset 1) reads 0x01 and the configuration register (offset 6) reads 0x00. The command register has stop at bit 0, run at bit 1, a transmit bit 2 that always reads 0, and the command field at bits 5:3 (bit 3 read, bit 4 write, bit 5 abort/complete). The status register has the reset flag at bit 0 and the completion flag at bit 6.
- R2: A command write with bit 0 set sets stop and clears run. Otherwise, a write with bit 1 set sets run and clears stop. Stop wins when both bits are written. In the command field, abort beats write and write beats read. A field of zero leaves the previous command in place.
- R3: The count is loaded at offsets 2 (low) and 3 (high), and the address at offsets 4 (low) and 5 (high). Reading these offsets returns the current count and the current address, including in the middle of a transfer.
- R4: In byte mode, a write to the data port (offset 15) during a running write transfer stores data bits 7:0 at the current address. The address then rises by 1 and the count falls by 1.
- R5: In word mode (offset 6, bit 0 set), each data port access moves 16 bits, with the low byte at the even address. The address rises by 2 and the count falls by 2. A count of 1 falls to 0.
- R6: A data port read during a running read transfer returns the RAM data at the current address on hst_rdata one cycle after the read strobe. In byte mode the byte is zero-extended.
- R7: The access that brings the count to zero sets the completion flag and returns the command field to abort/complete.
- R8: Writing a one to a status bit clears that bit and leaves the other bits as they are. Writing 0xFF clears every flag.
- R9: Data port accesses do nothing when the count is zero, when run is clear, or when the command does not match the access direction. Such accesses leave RAM, the count and the address unchanged, and an ignored read returns the last data value read.
- R10: During a read transfer, an address that steps onto the first byte of the ring stop page (offset 8) is replaced by the first byte of the ring start page (offset 7). Write transfers do not wrap.
- R11: An abort command sets the count to zero at once and does not set the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_addr | input | 4 | Register offset |
| hst_wr | input | 1 | Register write strobe |
| hst_rd | input | 1 | Register read strobe |
| hst_wdata | input | 16 | Write data (registers use bits 7:0) |
| hst_rdata | output | 16 | Read data, registered |
| ram_addr | output | ADDR_W-1 | Word address into the buffer RAM |
| ram_wdata | output | 16 | RAM write data |
| ram_be | output | 2 | RAM byte enables (bit 0 is the even byte) |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 16 | RAM read data, combinational from ram_addr |

## Verification
The bench builds the block with ADDR_W set to 12, which gives a 4 KB buffer of 16 pages. With this setting, random start addresses reach both the top of the address space and the ring stop boundary within a few dozen bytes. Ring pages are set close together (2 and 4) in the directed cases, so both byte and word reads cross the wrap point. Later random transfers use pages 1 and 15, so long reads wrap while writes run straight past. Odd counts in word mode exercise the case where the count floors at zero.

// File: rtl/rdma_port.sv
`timescale 1ns/1ps
module rdma_port #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        hst_addr,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [15:0]       hst_wdata,
  output logic [15:0]       hst_rdata,
  output logic [ADDR_W-2:0] ram_addr,
  output logic [15:0]       ram_wdata,
  output logic [1:0]        ram_be,
  output logic              ram_we,
  input  logic [15:0]       ram_rdata
);
  localparam int PW = ADDR_W - 8;
  localparam logic [3:0] A_CMD = 4'd0, A_ISR = 4'd1, A_CNTL = 4'd2, A_CNTH = 4'd3,
                         A_ADRL = 4'd4, A_ADRH = 4'd5, A_CFG = 4'd6, A_PST = 4'd7,
                         A_PSP = 4'd8, A_DATA = 4'd15;
  localparam logic [2:0] F_RD = 3'b001, F_WR = 3'b010, F_AB = 3'b100;

  logic [2:0]        cmd_f;
  logic              run_q, stop_q, isr_rst, isr_done, word_q;
  logic [15:0]       cnt, last_q;
  logic [ADDR_W-1:0] cur;
  logic [PW-1:0]     pg_start, pg_stop;

  logic              live, do_wr, do_rd, wrap_hit;
  logic [15:0]       step16, cnt_nx, cur16, rd_val;
  logic [ADDR_W-1:0] step_a, add_nx, cur_nx;

  assign live     = run_q && (cnt != 16'd0);
  assign do_wr    = hst_wr && hst_addr == A_DATA && live && cmd_f == F_WR;
  assign do_rd    = hst_rd && hst_addr == A_DATA && live && cmd_f == F_RD;
  assign step16   = word_q ? 16'd2 : 16'd1;
  assign step_a   = word_q ? ADDR_W'(2) : ADDR_W'(1);
  assign cnt_nx   = (cnt > step16) ? cnt - step16 : 16'd0;
  assign add_nx   = cur + step_a;
  assign wrap_hit = cmd_f == F_RD && add_nx[ADDR_W-1:8] == pg_stop && add_nx[7:0] == 8'h00;
  assign cur_nx   = wrap_hit ? {pg_start, 8'h00} : add_nx;
  assign cur16    = 16'(cur);
  assign rd_val   = word_q ? ram_rdata : {8'h00, cur[0] ? ram_rdata[15:8] : ram_rdata[7:0]};

  assign ram_addr  = cur[ADDR_W-1:1];
  assign ram_wdata = word_q ? hst_wdata : {hst_wdata[7:0], hst_wdata[7:0]};
  assign ram_be    = word_q ? 2'b11 : (cur[0] ? 2'b10 : 2'b01);
  assign ram_we    = do_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_f     <= F_AB;
      run_q     <= 1'b0;
      stop_q    <= 1'b1;
      isr_rst   <= 1'b1;
      isr_done  <= 1'b0;
      word_q    <= 1'b0;
      cnt       <= '0;
      cur       <= '0;
      pg_start  <= '0;
      pg_stop   <= '0;
      last_q    <= '0;
      hst_rdata <= '0;
    end else begin
      if (hst_wr) begin
        case (hst_addr)
          A_CMD: begin
            if (hst_wdata[5]) begin
              cmd_f <= F_AB;
              cnt   <= '0;
            end else if (hst_wdata[4]) cmd_f <= F_WR;
            else if (hst_wdata[3]) cmd_f <= F_RD;
            if (hst_wdata[0]) begin
              stop_q <= 1'b1;
              run_q  <= 1'b0;
            end else if (hst_wdata[1]) begin
              run_q  <= 1'b1;
              stop_q <= 1'b0;
            end
          end
          A_ISR: begin
            isr_rst  <= isr_rst & ~hst_wdata[0];
            isr_done <= isr_done & ~hst_wdata[6];
          end
          A_CNTL: cnt[7:0]  <= hst_wdata[7:0];
          A_CNTH: cnt[15:8] <= hst_wdata[7:0];
          A_ADRL: cur[7:0]  <= hst_wdata[7:0];
          A_ADRH: cur[ADDR_W-1:8] <= hst_wdata[PW-1:0];
          A_CFG:  word_q   <= hst_wdata[0];
          A_PST:  pg_start <= hst_wdata[PW-1:0];
          A_PSP:  pg_stop  <= hst_wdata[PW-1:0];
          default: ;
        endcase
      end
      if (hst_rd) begin
        case (hst_addr)
          A_CMD:  hst_rdata <= {8'h00, 2'b00, cmd_f, 1'b0, run_q, stop_q};
          A_ISR:  hst_rdata <= {8'h00, 1'b0, isr_done, 5'b00000, isr_rst};
          A_CNTL: hst_rdata <= {8'h00, cnt[7:0]};
          A_CNTH: hst_rdata <= {8'h00, cnt[15:8]};
          A_ADRL: hst_rdata <= {8'h00, cur16[7:0]};
          A_ADRH: hst_rdata <= {8'h00, cur16[15:8]};
          A_CFG:  hst_rdata <= {15'd0, word_q};
          A_PST:  hst_rdata <= {8'h00, 8'(pg_start)};
          A_PSP:  hst_rdata <= {8'h00, 8'(pg_stop)};
          A_DATA: begin
            if (do_rd) begin
              hst_rdata <= rd_val;
              last_q    <= rd_val;
            end else hst_rdata <= last_q;
          end
          default: hst_rdata <= '0;
        endcase
      end
      if (do_wr || do_rd) begin
        cnt <= cnt_nx;
        cur <= cur_nx;
        if (cnt_nx == 16'd0) begin
          isr_done <= 1'b1;
          cmd_f    <= F_AB;
        end
      end
    end
  end

  // R2
  run_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_q && stop_q));
  // R2
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(cmd_f));
  // R7
  done_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isr_done) |-> (cnt == 16'd0 && cmd_f == F_AB));
  // R11
  abort_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && hst_addr == A_CMD && hst_wdata[5] && !isr_done) |=> !isr_done);
  // R5
  count_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hst_wr && (hst_addr == A_CNTL || hst_addr == A_CNTH)) |=> cnt <= $past(cnt));
  // R9
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 16'd0) |-> !ram_we);
endmodule

// File: tb/rdma_port_bench.sv
`timescale 1ns/1ps
module rdma_port_bench;
  localparam int AW = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] hst_addr = '0;
  logic hst_wr = 1'b0, hst_rd = 1'b0;
  logic [15:0] hst_wdata = '0, hst_rdata;
  logic [AW-2:0] ram_addr;
  logic [15:0] ram_wdata, ram_rdata;
  logic [1:0] ram_be;
  logic ram_we;

  rdma_port #(.ADDR_W(AW)) u_rdma_port (
    .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_be(ram_be), .ram_we(ram_we), .ram_rdata(ram_rdata));

  always #4 clk = ~clk;

  logic [15:0] mem [0:2047];
  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) if (ram_we) begin
    if (ram_be[0]) mem[ram_addr][7:0]  <= ram_wdata[7:0];
    if (ram_be[1]) mem[ram_addr][15:8] <= ram_wdata[15:8];
  end

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [7:0] refm [0:4095];
  int ring_lo = 0, ring_hi = 0, ra = 0, rem = 0;
  bit rword = 0;
  logic [15:0] last_v = '0, v;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
    @(negedge clk); hst_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); hst_addr = a; hst_rd = 1'b1;
    @(negedge clk); hst_rd = 1'b0; d = hst_rdata;
  endtask

  function automatic int rnext(input int a, input bit word, input bit rd);
    int n = (a + (word ? 2 : 1)) & 12'hFFF;
    if (rd && (n >> 8) == ring_hi && (n & 8'hFF) == 0) n = ring_lo << 8;
    return n;
  endfunction

  function automatic int rstep(input int r, input bit word);
    int s = word ? 2 : 1;
    return (r > s) ? r - s : 0;
  endfunction

  task automatic setup(input bit word, input int a, input int cnt, input bit rd);
    wr_reg(6, {15'd0, word});
    wr_reg(2, 16'(cnt & 8'hFF)); wr_reg(3, 16'((cnt >> 8) & 8'hFF));
    wr_reg(4, 16'(a & 8'hFF));   wr_reg(5, 16'((a >> 8) & 8'hFF));
    wr_reg(0, rd ? 16'h000A : 16'h0012);
    ra = a; rword = word; rem = cnt;
  endtask

  task automatic put(input logic [15:0] d);
    wr_reg(15, d);
    if (rem > 0) begin
      if (rword) begin
        refm[ra & ~1] = d[7:0];
        refm[(ra & ~1) + 1] = d[15:8];
      end else refm[ra] = d[7:0];
      ra = rnext(ra, rword, 0);
      rem = rstep(rem, rword);
    end
  endtask

  task automatic get_chk(input string req);
    logic [15:0] e;
    rd_reg(15, v);
    if (rem > 0) begin
      e = rword ? {refm[(ra & ~1) + 1], refm[ra & ~1]} : {8'h00, refm[ra]};
      last_v = e;
      ra = rnext(ra, rword, 1);
      rem = rstep(rem, rword);
    end else e = last_v;
    chk(req, v, e);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    for (int i = 0; i < 4096; i++) refm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset pattern
    rd_reg(0, v); chk("R1", v, 16'h0021);
    rd_reg(1, v); chk("R1", v, 16'h0001);
    rd_reg(6, v); chk("R1", v, 16'h0000);
    // R8 selective and full clear
    wr_reg(1, 16'h0040); rd_reg(1, v); chk("R8", v, 16'h0001);
    wr_reg(1, 16'h00FF); rd_reg(1, v); chk("R8", v, 16'h0000);

    // R2 command decoding
    wr_reg(0, 16'h0003); rd_reg(0, v); chk("R2", v, 16'h0021);
    wr_reg(0, 16'h000A); rd_reg(0, v); chk("R2", v, 16'h000A);
    wr_reg(0, 16'h0002); rd_reg(0, v); chk("R2", v, 16'h000A);
    wr_reg(0, 16'h003A); rd_reg(0, v); chk("R2", v, 16'h0022);

    // R3 readback mid-transfer, R4 byte write
    setup(0, 12'h123, 5, 0);
    put(16'h0011); put(16'h0022);
    rd_reg(4, v); chk("R3", v, 16'h0025);
    rd_reg(5, v); chk("R3", v, 16'h0001);
    rd_reg(2, v); chk("R4", v, 16'h0003);
    // R11 abort
    wr_reg(0, 16'h0022); rem = 0;
    rd_reg(2, v); chk("R11", v, 16'h0000);
    rd_reg(1, v); chk("R11", v, 16'h0000);
    rd_reg(0, v); chk("R11", v, 16'h0022);

    // R9 ignored accesses
    setup(0, 12'h050, 2, 0); put(16'h0011); put(16'h0022); wr_reg(1, 16'h00FF);
    setup(0, 12'h050, 1, 0); put(16'h00AA);
    rd_reg(1, v); chk("R7", v, 16'h0040);
    rd_reg(0, v); chk("R7", v, 16'h0022);
    put(16'h0055);
    rd_reg(4, v); chk("R9", v, 16'h0051);
    wr_reg(1, 16'h0040);
    wr_reg(2, 16'h0001); wr_reg(3, 16'h0000); wr_reg(4, 16'h0051); wr_reg(5, 16'h0000);
    wr_reg(0, 16'h0011);
    wr_reg(15, 16'h0077);
    rd_reg(2, v); chk("R9", v, 16'h0001);
    rd_reg(4, v); chk("R9", v, 16'h0051);
    wr_reg(0, 16'h0022);
    setup(0, 12'h050, 2, 1);
    get_chk("R6"); get_chk("R9"); get_chk("R9");
    wr_reg(1, 16'h00FF);

    // R5 word write with odd count, read back bytewise
    setup(1, 12'h600, 3, 0); put(16'hBEEF); put(16'hCAFE);
    rd_reg(2, v); chk("R5", v, 16'h0000);
    rd_reg(4, v); chk("R5", v, 16'h0004);
    rd_reg(1, v); chk("R5", v, 16'h0040);
    wr_reg(1, 16'h0040);
    setup(0, 12'h600, 4, 1);
    for (int k = 0; k < 4; k++) get_chk("R6");
    wr_reg(1, 16'h0040);

    // R10 ring wrap on reads
    wr_reg(7, 16'h0002); wr_reg(8, 16'h0004); ring_lo = 2; ring_hi = 4;
    setup(0, 12'h3FE, 2, 0); put(16'h00A1); put(16'h00A2); wr_reg(1, 16'h0040);
    rd_reg(4, v); chk("R10", v, 16'h0000);
    rd_reg(5, v); chk("R10", v, 16'h0004);
    setup(0, 12'h200, 2, 0); put(16'h00B1); put(16'h00B2); wr_reg(1, 16'h0040);
    setup(0, 12'h3FE, 4, 1);
    for (int k = 0; k < 4; k++) get_chk("R10");
    rd_reg(4, v); chk("R10", v, 16'h0002);
    rd_reg(5, v); chk("R10", v, 16'h0002);
    wr_reg(1, 16'h0040);
    setup(1, 12'h3FE, 4, 1);
    get_chk("R10"); get_chk("R10");
    wr_reg(1, 16'h0040);

    // random transfers, R4 R5 R6 R7 R10
    wr_reg(7, 16'h0001); wr_reg(8, 16'h000F); ring_lo = 1; ring_hi = 15;
    for (int it = 0; it < 24; it++) begin
      bit w = 1'($urandom % 2);
      int a = int'($urandom % 4096);
      int c = 1 + int'($urandom % 40);
      int n;
      if (w) a = a & ~1;
      n = w ? (c + 1) / 2 : c;
      setup(w, a, c, 0);
      for (int k = 0; k < n; k++) put(16'($urandom));
      rd_reg(1, v); chk("R7", v, 16'h0040);
      rd_reg(0, v); chk("R7", v, 16'h0022);
      wr_reg(1, 16'h0040);
      setup(w, a, c, 1);
      for (int k = 0; k < n; k++) get_chk(w ? "R5" : "R6");
      rd_reg(1, v); chk("R7", v, 16'h0040);
      wr_reg(1, 16'h00FF);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule